// File: doc/BRIEF.md
# Multi-Cycle Eight-Register Processor Core

This block is a small 32-bit processor that runs each instruction as a sequence of one-clock steps. A single adder/NOR unit and a single memory port are shared across those steps. Holding registers keep the instruction word, the last unit result, the loaded data word and the two source operands, so later steps never repeat earlier work. Because of this, each operation takes only as many clocks as it needs: two for a no-op, four for register arithmetic, stores and branches, and five for loads.

Instructions and data live in one external memory. Writes to it land on the rising clock edge when the write strobe is high. Read data is a combinational function of the address the core drives in the same cycle. A separate sequencer module steps through the fetch, decode and per-operation states and drives every enable and select in the datapath. After the halt operation the core freezes and raises its halted output.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low the core drives `mem_we` low, `halted` low and `mem_addr` to 0. The first instruction is fetched from address 0 in the first cycle after release.
- R2: Each instruction starts with a fetch cycle, in which `mem_addr` equals the PC and `mem_we` is low, followed by a decode cycle that advances the PC by one. Instruction fields are: opcode [24:22], first source register [21:19], second source register [18:16], destination register [2:0] and a 16-bit offset [15:0]. Opcode 7 (no-op) and the unassigned opcode 5 return to fetch after decode, so they take 2 cycles.
- R3: Opcode 0 (sum) and opcode 1 (bitwise NOR) take 4 cycles and write the result of the two source registers into the destination register. Register 0 is an ordinary writable register.
- R4: Opcode 2 (load) takes 5 cycles and writes the memory word at first-source + offset into the second source register.
- R5: Opcode 3 (store) takes 4 cycles. It writes the second source register to address first-source + offset, with `mem_we` high in exactly its fourth cycle. No other operation raises `mem_we`.
- R6: The offset is a 16-bit two's-complement value, sign-extended before it is added.
- R7: Opcode 4 (branch on equal) takes 4 cycles. When the two source registers are equal, the next fetch is at the branch address + 1 + offset. Otherwise the next fetch is at the branch address + 1.
- R8: For opcode 6 (halt), `halted` rises in the third cycle after the halt is fetched and stays high. From then on `mem_we` stays low and `mem_addr` holds the halt address + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address to the shared memory |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Memory write strobe, one cycle per store |
| mem_rdata | input | 32 | Combinational read data for `mem_addr` |
| halted | output | 1 | High once a halt has been decoded |

## Verification
The cases hardest to reach from the ports are those whose effect is invisible: a taken branch that must skip a store, a branch that must not be taken, and register 0 being written and then used as a base. Each of these can only be seen through a later store, or through the absence of one. The program therefore routes every intermediate result into a store whose address, data and exact cycle are predicted from the per-opcode cycle counts. The skipped instructions are stores to addresses no other instruction touches. The scoreboard also expects every fetch at a predicted cycle and address, so a wrong cycle count or a wrong branch target shows up as soon as it happens.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NOR  = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_RSV  = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_WB_ALU,
    ST_LW_ADDR,
    ST_LW_READ,
    ST_LW_WB,
    ST_SW_ADDR,
    ST_SW_WRITE,
    ST_BR_TGT,
    ST_BR_RESOLVE,
    ST_HALT
  } step_e;

  typedef enum logic [1:0] {
    OPB_REGB,
    OPB_IMM,
    OPB_ONE,
    OPB_ZERO
  } opb_e;

  typedef enum logic {
    FN_ADD,
    FN_NOR
  } fn_e;

  typedef struct packed {
    logic ir_en;
    logic pc_en;
    logic pc_cond;
    logic opa_pc;
    opb_e opb;
    fn_e  fn;
    logic res_en;
    logic mdr_en;
    logic ab_en;
    logic rf_we;
    logic rf_dst_b;
    logic rf_from_mdr;
    logic mem_from_res;
    logic mem_we;
    logic halted;
  } ctl_t;

  localparam int OPC_LSB  = 22;
  localparam int SRCA_LSB = 19;
  localparam int SRCB_LSB = 16;
  localparam int DST_LSB  = 0;

endpackage

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e opcode,
  output step_e   step,
  output ctl_t    ctl
);

  step_e step_q;
  step_e step_d;

  function automatic step_e dispatch(input opcode_e op);
    case (op)
      OP_ADD, OP_NOR: dispatch = ST_EXEC;
      OP_LW:          dispatch = ST_LW_ADDR;
      OP_SW:          dispatch = ST_SW_ADDR;
      OP_BEQ:         dispatch = ST_BR_TGT;
      OP_HALT:        dispatch = ST_HALT;
      default:        dispatch = ST_FETCH;
    endcase
  endfunction

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_FETCH:      step_d = ST_DECODE;
      ST_DECODE:     step_d = dispatch(opcode);
      ST_EXEC:       step_d = ST_WB_ALU;
      ST_WB_ALU:     step_d = ST_FETCH;
      ST_LW_ADDR:    step_d = ST_LW_READ;
      ST_LW_READ:    step_d = ST_LW_WB;
      ST_LW_WB:      step_d = ST_FETCH;
      ST_SW_ADDR:    step_d = ST_SW_WRITE;
      ST_SW_WRITE:   step_d = ST_FETCH;
      ST_BR_TGT:     step_d = ST_BR_RESOLVE;
      ST_BR_RESOLVE: step_d = ST_FETCH;
      ST_HALT:       step_d = ST_HALT;
      default:       step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_d;
  end

  always_comb begin
    ctl = '0;
    ctl.opb = OPB_REGB;
    ctl.fn  = FN_ADD;
    case (step_q)
      ST_FETCH: begin
        ctl.ir_en  = 1'b1;
        ctl.opa_pc = 1'b1;
        ctl.opb    = OPB_ONE;
        ctl.res_en = 1'b1;
      end
      ST_DECODE: begin
        ctl.pc_en = 1'b1;
        ctl.ab_en = 1'b1;
      end
      ST_EXEC: begin
        ctl.res_en = 1'b1;
        ctl.fn     = (opcode == OP_NOR) ? FN_NOR : FN_ADD;
      end
      ST_WB_ALU: ctl.rf_we = 1'b1;
      ST_LW_ADDR, ST_SW_ADDR: begin
        ctl.res_en = 1'b1;
        ctl.opb    = OPB_IMM;
      end
      ST_LW_READ: begin
        ctl.mem_from_res = 1'b1;
        ctl.mdr_en       = 1'b1;
      end
      ST_LW_WB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_dst_b    = 1'b1;
        ctl.rf_from_mdr = 1'b1;
      end
      ST_SW_WRITE: begin
        ctl.mem_from_res = 1'b1;
        ctl.mem_we       = 1'b1;
      end
      ST_BR_TGT: begin
        ctl.opa_pc = 1'b1;
        ctl.opb    = OPB_IMM;
        ctl.res_en = 1'b1;
      end
      ST_BR_RESOLVE: ctl.pc_cond = 1'b1;
      ST_HALT:       ctl.halted  = 1'b1;
      default: ;
    endcase
  end

  assign step = step_q;

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  assign rd_a = regs_q[rd_a_idx];
  assign rd_b = regs_q[rd_b_idx];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  fn_e               fn,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (fn)
      FN_NOR:  y = ~(opa | opb);
      default: y = opa + opb;
    endcase
  end

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int NREG   = 8,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  localparam int IDX_W = $clog2(NREG);
  localparam int TOP_W = OPC_LSB + 3;

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;

  step_e   step_q;
  ctl_t    ctl;
  opcode_e opcode;

  logic [IDX_W-1:0]  src_a_idx;
  logic [IDX_W-1:0]  src_b_idx;
  logic [IDX_W-1:0]  dst_idx;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] rf_a;
  logic [DATA_W-1:0] rf_b;
  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_y;
  logic              pc_we;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              unused_ir_hi;

  assign opcode    = opcode_e'(ir_q[OPC_LSB +: 3]);
  assign src_a_idx = ir_q[SRCA_LSB +: IDX_W];
  assign src_b_idx = ir_q[SRCB_LSB +: IDX_W];
  assign dst_idx   = ir_q[DST_LSB +: IDX_W];
  assign imm_ext   = {{(DATA_W-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};
  assign unused_ir_hi = ^ir_q[DATA_W-1:TOP_W];

  mc_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .step   (step_q),
    .ctl    (ctl)
  );

  mc_regfile #(
    .NREG   (NREG),
    .DATA_W (DATA_W)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (src_a_idx),
    .rd_b_idx (src_b_idx),
    .rd_a     (rf_a),
    .rd_b     (rf_b),
    .wr_en    (ctl.rf_we),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  always_comb begin
    alu_a = ctl.opa_pc ? {{(DATA_W-ADDR_W){1'b0}}, pc_q} : a_q;
    case (ctl.opb)
      OPB_IMM:  alu_b = imm_ext;
      OPB_ONE:  alu_b = {{(DATA_W-1){1'b0}}, 1'b1};
      OPB_ZERO: alu_b = '0;
      default:  alu_b = b_q;
    endcase
  end

  mc_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .opa (alu_a),
    .opb (alu_b),
    .fn  (ctl.fn),
    .y   (alu_y)
  );

  assign pc_we   = ctl.pc_en | (ctl.pc_cond & (a_q == b_q));
  assign wr_idx  = ctl.rf_dst_b ? src_b_idx : dst_idx;
  assign wr_data = ctl.rf_from_mdr ? mdr_q : res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      res_q <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      if (pc_we)      pc_q  <= res_q[ADDR_W-1:0];
      if (ctl.ir_en)  ir_q  <= mem_rdata;
      if (ctl.res_en) res_q <= alu_y;
      if (ctl.mdr_en) mdr_q <= mem_rdata;
      if (ctl.ab_en) begin
        a_q <= rf_a;
        b_q <= rf_b;
      end
    end
  end

  assign mem_addr  = ctl.mem_from_res ? res_q[ADDR_W-1:0] : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl.mem_we;
  assign halted    = ctl.halted;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              halted,
  input step_e             step,
  input logic [ADDR_W-1:0] pc
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!mem_we && !halted && mem_addr == '0));

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_FETCH) |-> (mem_addr == pc && !mem_we));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_DECODE) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(mem_addr));

endmodule

bind mc_core mc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .halted   (halted),
  .step     (step_q),
  .pc       (pc_q)
);

// File: tb/test_mc_core.sv
module test_mc_core;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halted;

  logic [DW-1:0] mem [64];

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  run = 0;
  bit  done = 0;
  int  t_plan = 0;
  int  halt_cyc = -1;

  typedef struct {
    int            cyc;
    bit            st;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  mc_core i_mc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  assign mem_rdata = mem[mem_addr[5:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
  always @(posedge clk) if (run) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc_r(input int op, input int a, input int b, input int d);
    return (DW'(op) << 22) | (DW'(a) << 19) | (DW'(b) << 16) | DW'(d);
  endfunction

  function automatic logic [DW-1:0] enc_i(input int op, input int a, input int b, input int off);
    return (DW'(op) << 22) | (DW'(a) << 19) | (DW'(b) << 16) | (DW'(off) & 32'h0000_FFFF);
  endfunction

  // expect a fetch at pc now, then the instruction occupies ncyc cycles
  task automatic plan_instr(input int pc, input int ncyc, input string tag);
    sb.push_back('{t_plan, 1'b0, AW'(pc), '0, tag});
    t_plan += ncyc;
  endtask

  // store: fetch now, write in its fourth cycle
  task automatic plan_store(input int pc, input int addr, input logic [DW-1:0] data, input string tag);
    sb.push_back('{t_plan, 1'b0, AW'(pc), '0, tag});
    sb.push_back('{t_plan + 3, 1'b1, AW'(addr), data, tag});
    t_plan += 4;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (run && !done) begin
      if (sb.size() > 0 && sb[0].cyc < cyc) begin
        check(1'b0, sb[0].tag, "missed event", DW'(cyc), DW'(sb[0].cyc));
        void'(sb.pop_front());
      end
      if (mem_we) begin
        if (sb.size() > 0 && sb[0].cyc == cyc && sb[0].st) begin
          check(mem_addr == sb[0].addr, sb[0].tag, "store address", DW'(mem_addr), DW'(sb[0].addr));
          check(mem_wdata == sb[0].data, sb[0].tag, "store data", mem_wdata, sb[0].data);
          void'(sb.pop_front());
        end else begin
          check(1'b0, "R5", "unexpected write", DW'(mem_addr), '0);
        end
      end else if (sb.size() > 0 && sb[0].cyc == cyc) begin
        if (sb[0].st) check(1'b0, sb[0].tag, "missing write", DW'(mem_we), 32'd1);
        else check(mem_addr == sb[0].addr, sb[0].tag, "fetch address", DW'(mem_addr), DW'(sb[0].addr));
        void'(sb.pop_front());
      end
      if (halt_cyc >= 0)
        check(halted == (cyc >= halt_cyc), "R8", "halted level", DW'(halted), DW'(cyc >= halt_cyc));
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // program
    mem[0]  = enc_i(2, 0, 1, 20);   // lw  r1 <- mem[20]
    mem[1]  = enc_i(2, 0, 2, 21);   // lw  r2 <- mem[21]
    mem[2]  = enc_r(0, 1, 2, 3);    // add r3 = r1 + r2
    mem[3]  = enc_i(3, 0, 3, 30);   // sw  r3 -> 30
    mem[4]  = enc_r(1, 1, 2, 4);    // nor r4
    mem[5]  = enc_i(3, 0, 4, 31);   // sw  r4 -> 31
    mem[6]  = enc_i(4, 1, 1, 1);    // beq taken, skips 7
    mem[7]  = enc_i(3, 0, 1, 40);   // must be skipped
    mem[8]  = enc_i(4, 1, 2, 5);    // beq not taken
    mem[9]  = enc_r(7, 0, 0, 0);    // noop
    mem[10] = enc_r(5, 0, 0, 0);    // unassigned opcode
    mem[11] = enc_r(0, 1, 1, 0);    // add r0 = r1 + r1
    mem[12] = enc_i(3, 0, 0, 22);   // sw  r0 -> r0+22
    mem[13] = enc_i(3, 0, 1, -1);   // sw  r1 -> r0-1
    mem[14] = enc_i(2, 0, 5, 22);   // lw  r5 <- mem[r0+22]
    mem[15] = enc_i(4, 0, 5, 1);    // beq r0,r5 taken, skips 16
    mem[16] = enc_i(3, 0, 1, 41);   // must be skipped
    mem[17] = enc_i(3, 0, 5, 23);   // sw  r5 -> r0+23
    mem[18] = enc_r(6, 0, 0, 0);    // halt
    mem[20] = 32'd5;
    mem[21] = 32'h0000_00F0;

    // expected schedule
    plan_instr(0, 5, "R4");
    plan_instr(1, 5, "R4");
    plan_instr(2, 4, "R3");
    plan_store(3, 30, 32'd245, "R3");
    plan_instr(4, 4, "R3");
    plan_store(5, 31, 32'hFFFF_FF0A, "R3");
    plan_instr(6, 4, "R7");
    plan_instr(8, 4, "R7");
    plan_instr(9, 2, "R7");
    plan_instr(10, 2, "R2");
    plan_instr(11, 2 + 2, "R2");
    plan_store(12, 32, 32'd10, "R3");
    plan_store(13, 9, 32'd5, "R6");
    plan_instr(14, 5, "R4");
    plan_instr(15, 4, "R4");
    plan_store(17, 33, 32'd10, "R7");
    plan_instr(18, 0, "R8");
    halt_cyc = t_plan + 2;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_we == 1'b0, "R1", "reset mem_we", DW'(mem_we), '0);
    check(halted == 1'b0, "R1", "reset halted", DW'(halted), '0);
    check(mem_addr == '0, "R1", "reset address", DW'(mem_addr), '0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    run = 1'b1;

    fork
      begin
        wait (cyc >= halt_cyc + 12);
      end
      begin
        repeat (2000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", DW'(cyc), DW'(halt_cyc));
      end
    join_any
    disable fork;
    @(negedge clk);
    done = 1'b1;

    check(sb.size() == 0, "R2", "unconsumed expectations", DW'(sb.size()), '0);
    check(halted == 1'b1, "R8", "final halted", DW'(halted), 32'd1);
    check(mem_addr == AW'(19), "R8", "frozen address", DW'(mem_addr), 32'd19);
    check(mem[40] == '0, "R7", "skipped store 40", mem[40], '0);
    check(mem[41] == '0, "R7", "skipped store 41", mem[41], '0);
    check(mem[32] == 32'd10, "R3", "register 0 as data", mem[32], 32'd10);
    check(mem[9] == 32'd5, "R6", "negative offset target", mem[9], 32'd5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule